// File: doc/BRIEF.md
# I2C Target Interface with Address Matching

This block is the target (slave) side of a two-wire serial bus. It watches the clock and data lines through a synchroniser, recognises Start and Stop conditions, and moves bytes on the data line, most significant bit first, in step with the bus clock. The first byte after a Start is compared with a programmable own address. Seven-bit and ten-bit addressing are supported, and the all-zero general call address can optionally be accepted. The block acknowledges accepted bytes by pulling the data line low during the ninth clock. It releases the line for bytes it does not accept.

The host sees four byte-wide locations behind a select field: a data buffer, the low address byte, a configuration byte, and a status byte. Received data bytes are assembled in a hidden shift register and copied into the buffer when they complete, which gives a double-buffered receiver. For transmit there is no second buffer. A host write to the data location loads the buffer and the shift register together. Before each transmitted byte the block holds the bus clock low until that write arrives. A one-cycle interrupt pulse tells the host about Start, Stop, a newly buffered byte, and a transmit request.

Top module: `i2c_target_core`

## Requirements
- R1: A Start (data falling while clock high) sets status bit 0 and clears status bit 1. A Stop (data rising while clock high) sets bit 1 and clears bit 0. Both bits are 0 after reset.
- R2: `irq` is a one-cycle pulse for each Start, each Stop, each data byte copied to the buffer, and each transmit clock hold.
- R3: With configuration bit 0 clear (7-bit mode), a first byte whose bits 7:1 equal address register bits 6:0 is acknowledged. In that byte, bit 0 set means the master reads. On a mismatch, `sda_oe` stays low and every later byte is ignored until the next Start.
- R4: The first byte 0x00 is acknowledged as a general call only while configuration bit 1 is set. Acceptance sets status bit 5 until the next Start.
- R5: With configuration bit 0 set (10-bit mode), a first byte of 11110, then configuration bits 3:2, then a 0 is acknowledged. The next byte must equal the address register, or it is not acknowledged.
- R6: A first byte of 11110, then configuration bits 3:2, then a 1 is acknowledged only after a full 10-bit match earlier in the same transaction (before the repeated Start). Acknowledging it starts transmit.
- R7: A data byte after an accepted write address is acknowledged and copied to the buffer (select 0), and status bit 2 is set. A host read of select 0 clears bit 2.
- R8: If a data byte completes while status bit 2 is set, it is not acknowledged, status bit 3 is set, and the buffer keeps the old byte. Writing select 3 with bit 3 set clears status bit 3.
- R9: A host read of select 0 in the same cycle that a byte completes frees the buffer. The new byte is acknowledged and buffered, and status bit 3 stays clear.
- R10: After a read address is accepted, `scl_oe` holds the clock low until the host writes select 0. That write releases the clock and the byte is sent MSB first. Status bit 4 is set while transmitting.
- R11: A master acknowledge after a transmitted byte starts a new clock hold. A master no-acknowledge releases the bus, and bytes are ignored until the next Start.
- R12: After reset, `sda_oe`, `scl_oe` and `irq` are low and the status byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull the data line low when 1 |
| scl_oe | output | 1 | Pull the clock line low (hold) when 1 |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Write select: 0 data, 1 address low, 2 configuration, 3 status |
| wdata | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe (side effect only for select 0) |
| rd_sel | input | 2 | Read select, same map as `wr_sel` |
| rdata | output | 8 | Read data for `rd_sel` |
| irq | output | 1 | Event pulse |

## Verification
Two things can fall in the same cycle: the host draining the buffer and the engine deciding whether a newly completed byte fits. The bench fills the buffer and then clocks in a second byte. It places the host read of the buffer in exactly the cycle in which the synchronised clock fall after the eighth bit reaches the engine. The expected result is an acknowledge, the old byte returned by that read, the new byte left in the buffer, and overflow still clear. A second run without the read must give a no-acknowledge, the overflow flag, and the old byte kept.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_ADDR = 2'd1;
    localparam logic [1:0] SEL_CFG  = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam logic [4:0] TEN_PREFIX = 5'b11110;
    localparam logic [7:0] GC_ADDR    = 8'h00;

    typedef enum logic [1:0] {
        PH_ADDR1  = 2'd0,
        PH_ADDR2  = 2'd1,
        PH_RXDATA = 2'd2,
        PH_TXDATA = 2'd3
    } phase_e;

    typedef struct packed {
        logic       ten;
        logic       gc_en;
        logic [9:0] own;
    } tgt_cfg_t;

    // Outcome of a completed received byte
    typedef struct packed {
        logic   ack;
        logic   stay;
        logic   load;
        logic   ovf;
        logic   ten_ok;
        logic   gc;
        phase_e nxt;
    } verdict_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s && !scl_q;
    assign scl_fall  = !scl_s && scl_q;
    assign start_evt = scl_s && scl_q && sda_q && !sda_s;
    assign stop_evt  = scl_s && scl_q && !sda_q && sda_s;
endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
    import i2c_tgt_pkg::*;
(
    input  phase_e              phase,
    input  logic [BYTE_W-1:0]   rx_byte,
    input  tgt_cfg_t            cfg,
    input  logic                ten_ok,
    input  logic                buf_busy,
    output verdict_t            v
);
    always_comb begin
        v     = '0;
        v.nxt = PH_RXDATA;
        case (phase)
            PH_ADDR1: begin
                if (cfg.ten && rx_byte[7:3] == TEN_PREFIX && rx_byte[2:1] == cfg.own[9:8]) begin
                    if (!rx_byte[0]) begin
                        v.ack = 1'b1; v.stay = 1'b1; v.nxt = PH_ADDR2;
                    end else if (ten_ok) begin
                        v.ack = 1'b1; v.stay = 1'b1; v.nxt = PH_TXDATA;
                    end
                end else if (!cfg.ten && rx_byte[7:1] == cfg.own[6:0]) begin
                    v.ack  = 1'b1;
                    v.stay = 1'b1;
                    v.nxt  = rx_byte[0] ? PH_TXDATA : PH_RXDATA;
                end else if (cfg.gc_en && rx_byte == GC_ADDR) begin
                    v.ack = 1'b1; v.stay = 1'b1; v.gc = 1'b1;
                end
            end
            PH_ADDR2: begin
                if (rx_byte == cfg.own[7:0]) begin
                    v.ack = 1'b1; v.stay = 1'b1; v.ten_ok = 1'b1;
                end
            end
            PH_RXDATA: begin
                v.stay = 1'b1;
                if (buf_busy) v.ovf = 1'b1;
                else begin
                    v.ack  = 1'b1;
                    v.load = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  verdict_t          v,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output phase_e            phase,
    output logic [BYTE_W-1:0] shift,
    output logic              active,
    output logic              ten_ok,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              rx_load,
    output logic              ovf_evt,
    output logic              gc_evt,
    output logic              hold_evt
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    logic [CNT_W-1:0] cnt;
    logic             in_ack, keep, mnack;
    phase_e           nxt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_ADDR1; shift <= '0; active <= 1'b0; ten_ok <= 1'b0;
            sda_oe <= 1'b0; scl_oe <= 1'b0; cnt <= '0; in_ack <= 1'b0;
            keep <= 1'b0; mnack <= 1'b0; nxt_q <= PH_RXDATA;
            rx_load <= 1'b0; ovf_evt <= 1'b0; gc_evt <= 1'b0; hold_evt <= 1'b0;
        end else begin
            rx_load  <= 1'b0;
            ovf_evt  <= 1'b0;
            gc_evt   <= 1'b0;
            hold_evt <= 1'b0;
            if (tx_load) begin
                shift <= tx_byte;
                if (scl_oe) begin
                    scl_oe <= 1'b0;
                    sda_oe <= ~tx_byte[BYTE_W-1];
                end
            end
            if (start_evt) begin
                active <= 1'b1; phase <= PH_ADDR1; cnt <= '0;
                in_ack <= 1'b0; sda_oe <= 1'b0; scl_oe <= 1'b0;
            end else if (stop_evt) begin
                active <= 1'b0; ten_ok <= 1'b0; in_ack <= 1'b0;
                sda_oe <= 1'b0; scl_oe <= 1'b0;
            end else if (active) begin
                if (scl_rise) begin
                    if (!in_ack && cnt < LAST) begin
                        if (phase != PH_TXDATA) shift <= {shift[BYTE_W-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (in_ack && phase == PH_TXDATA) begin
                        mnack <= sda_s;
                    end
                end else if (scl_fall) begin
                    if (in_ack) begin
                        in_ack <= 1'b0;
                        cnt    <= '0;
                        sda_oe <= 1'b0;
                        if (phase == PH_TXDATA) begin
                            if (mnack) active <= 1'b0;
                            else begin
                                scl_oe <= 1'b1; hold_evt <= 1'b1;
                            end
                        end else if (!keep) begin
                            active <= 1'b0;
                        end else begin
                            phase <= nxt_q;
                            if (nxt_q == PH_TXDATA) begin
                                scl_oe <= 1'b1; hold_evt <= 1'b1;
                            end
                        end
                    end else if (cnt == LAST) begin
                        in_ack <= 1'b1;
                        if (phase == PH_TXDATA) sda_oe <= 1'b0;
                        else begin
                            sda_oe  <= v.ack;
                            keep    <= v.stay;
                            nxt_q   <= v.nxt;
                            rx_load <= v.load;
                            ovf_evt <= v.ovf;
                            gc_evt  <= v.gc;
                            if (v.ten_ok) ten_ok <= 1'b1;
                        end
                    end else if (phase == PH_TXDATA && cnt != '0) begin
                        shift  <= {shift[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~shift[BYTE_W-2];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       scl_oe,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wdata,
    input  logic       rd_en,
    input  logic [1:0] rd_sel,
    output logic [7:0] rdata,
    output logic       irq
);
    logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [BYTE_W-1:0] buf_q, own_lo_q, eng_shift;
    logic [3:0] cfg_q;
    logic buf_full, ovf_q, gc_hit_q, start_seen_q, stop_seen_q;
    logic eng_active, eng_ten_ok, rx_load, ovf_evt, gc_evt, hold_evt;
    phase_e   eng_phase;
    tgt_cfg_t cfg;
    verdict_t verdict;
    logic rd_buf, wr_buf, buf_busy;

    assign cfg      = '{ten: cfg_q[0], gc_en: cfg_q[1], own: {cfg_q[3:2], own_lo_q}};
    assign rd_buf   = rd_en && rd_sel == SEL_DATA;
    assign wr_buf   = wr_en && wr_sel == SEL_DATA;
    assign buf_busy = buf_full && !rd_buf;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2c_tgt_match u_match (
        .phase(eng_phase), .rx_byte(eng_shift), .cfg(cfg),
        .ten_ok(eng_ten_ok), .buf_busy(buf_busy), .v(verdict)
    );

    i2c_tgt_engine u_eng (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .v(verdict),
        .tx_load(wr_buf), .tx_byte(wdata), .phase(eng_phase), .shift(eng_shift),
        .active(eng_active), .ten_ok(eng_ten_ok), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .rx_load(rx_load), .ovf_evt(ovf_evt), .gc_evt(gc_evt), .hold_evt(hold_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0; own_lo_q <= '0; cfg_q <= '0; buf_full <= 1'b0;
            ovf_q <= 1'b0; gc_hit_q <= 1'b0; start_seen_q <= 1'b0;
            stop_seen_q <= 1'b0; irq <= 1'b0;
        end else begin
            if (start_evt) begin
                start_seen_q <= 1'b1; stop_seen_q <= 1'b0; gc_hit_q <= 1'b0;
            end
            if (stop_evt) begin
                stop_seen_q <= 1'b1; start_seen_q <= 1'b0;
            end
            if (rd_buf) buf_full <= 1'b0;
            if (wr_en) begin
                case (wr_sel)
                    SEL_DATA: buf_q    <= wdata;
                    SEL_ADDR: own_lo_q <= wdata;
                    SEL_CFG:  cfg_q    <= wdata[3:0];
                    default:  if (wdata[3]) ovf_q <= 1'b0;
                endcase
            end
            if (rx_load) begin
                buf_q    <= eng_shift;
                buf_full <= 1'b1;
            end
            if (ovf_evt) ovf_q <= 1'b1;
            if (gc_evt) gc_hit_q <= 1'b1;
            irq <= start_evt || stop_evt || rx_load || hold_evt;
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_DATA: rdata = buf_q;
            SEL_ADDR: rdata = own_lo_q;
            SEL_CFG:  rdata = {4'b0, cfg_q};
            default:  rdata = {2'b0, gc_hit_q, eng_active && eng_phase == PH_TXDATA,
                               ovf_q, buf_full, stop_seen_q, start_seen_q};
        endcase
    end
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic       start_seen,
    input logic       stop_seen,
    input logic       irq,
    input logic       buf_full,
    input logic       ovf,
    input logic       sda_oe,
    input logic       scl_oe,
    input logic       active,
    input logic       start_evt,
    input logic       stop_evt
);
    p_bus_state_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(start_seen && stop_seen));

    p_irq_on_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(start_seen) |-> irq);

    p_irq_on_load_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(buf_full) |-> irq);

    p_no_ack_on_ovf_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> (!sda_oe && buf_full));

    p_hold_release_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_oe) |-> ($past(wr_en && wr_sel == SEL_DATA) || $past(start_evt) || $past(stop_evt)));

    p_quiet_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> active);
endmodule

bind i2c_target_core i2c_tgt_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .start_seen(start_seen_q), .stop_seen(stop_seen_q), .irq(irq),
    .buf_full(buf_full), .ovf(ovf_q), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .active(eng_active), .start_evt(start_evt), .stop_evt(stop_evt)
);

// File: tb/sim_i2c_target_core.sv
module sim_i2c_target_core;
    localparam int HALF = 8;
    localparam int NV   = 8;
    // {ten, gc_en, own[9:0], first byte, expected ack}
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 1'b0, 10'h05A, 8'hB4, 1'b1},
        {1'b0, 1'b0, 10'h05A, 8'hB6, 1'b0},
        {1'b0, 1'b1, 10'h05A, 8'h00, 1'b1},
        {1'b0, 1'b0, 10'h05A, 8'h00, 1'b0},
        {1'b1, 1'b0, 10'h2A5, 8'hF4, 1'b1},
        {1'b1, 1'b0, 10'h2A5, 8'hF2, 1'b0},
        {1'b1, 1'b1, 10'h2A5, 8'h00, 1'b1},
        {1'b0, 1'b0, 10'h07F, 8'hFE, 1'b1}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, scl_oe, irq;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] wr_sel = '0, rd_sel = '0;
    logic [7:0] wdata = '0, rdata;
    logic scl_line, sda_line;
    int checks = 0, errors = 0, irq_cnt = 0, cyc = 0;
    logic [7:0] same_rd;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    i2c_target_core u0 (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .wr_en(wr_en), .wr_sel(wr_sel),
        .wdata(wdata), .rd_en(rd_en), .rd_sel(rd_sel), .rdata(rdata), .irq(irq)
    );

    always @(posedge clk) begin
        if (irq) irq_cnt <= irq_cnt + 1;
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] sel, input logic strobe, output logic [7:0] d);
        @(negedge clk);
        rd_sel = sel; rd_en = strobe;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic scl_high();
        scl_m = 1'b1;
        @(negedge clk);
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HALF);
        scl_high(); tick(HALF);
        sda_m = 1'b0; tick(HALF);
        scl_m = 1'b0; tick(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HALF);
        scl_high(); tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic rd_at_done, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HALF);
            scl_high(); tick(HALF);
            scl_m = 1'b0;
            if (i == 0 && rd_at_done) begin
                @(posedge clk); @(posedge clk); @(negedge clk);
                rd_sel = 2'd0; rd_en = 1'b1;
                #1 same_rd = rdata;
                @(negedge clk);
                rd_en = 1'b0;
            end
        end
        sda_m = 1'b1; tick(HALF);
        scl_high(); tick(HALF);
        ack = ~sda_line;
        scl_m = 1'b0; tick(HALF);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(HALF);
            scl_high(); tick(HALF);
            b[i] = sda_line;
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; tick(HALF);
        scl_high(); tick(HALF);
        scl_m = 1'b0; tick(HALF);
        sda_m = 1'b1; tick(HALF);
    endtask

    task automatic configure(input logic ten, input logic gc, input logic [9:0] own);
        host_write(2'd1, own[7:0]);
        host_write(2'd2, {4'b0, own[9:8], gc, ten});
    endtask

    task automatic serve_read(input logic [7:0] txd, input logic give_ack, input string req, output logic [7:0] got);
        fork
            read_byte(give_ack, got);
            begin
                logic [7:0] st;
                wait (scl_oe == 1'b1);
                tick(2);
                chk({req, " clock held low"}, {31'b0, scl_line}, 32'd0);
                host_read(2'd3, 1'b0, st);
                chk({req, " status bit4 transmitting"}, {31'b0, st[4]}, 32'd1);
                host_write(2'd0, txd);
            end
        join
    endtask

    initial begin
        logic ack;
        logic [7:0] d, st;
        int irq0;

        tick(5);
        rst = 1'b0;
        tick(2);
        // R12: reset state
        chk("R12 sda_oe", {31'b0, sda_oe}, 32'd0);
        chk("R12 scl_oe", {31'b0, scl_oe}, 32'd0);
        chk("R12 irq", {31'b0, irq}, 32'd0);
        host_read(2'd3, 1'b0, st);
        chk("R12 status", {24'b0, st}, 32'd0);

        // Vector table: first-byte address decisions (R3, R4, R5)
        for (int k = 0; k < NV; k++) begin
            configure(VEC[k][20], VEC[k][19], VEC[k][18:9]);
            bus_start();
            send_byte(VEC[k][8:1], 1'b0, ack);
            chk($sformatf("R3/R4/R5 vector %0d ack", k), {31'b0, ack}, {31'b0, VEC[k][0]});
            if (VEC[k][8:1] == 8'h00 && VEC[k][0]) begin
                host_read(2'd3, 1'b0, st);
                chk("R4 general call status bit5", {31'b0, st[5]}, 32'd1);
            end
            bus_stop();
        end

        // R1, R2, R7, R8, R9 in one write transaction
        configure(1'b0, 1'b0, 10'h05A);
        irq0 = irq_cnt;
        bus_start();
        host_read(2'd3, 1'b0, st);
        chk("R1 start sets bit0", {31'b0, st[0]}, 32'd1);
        chk("R1 start clears bit1", {31'b0, st[1]}, 32'd0);
        chk("R2 irq on start", irq_cnt - irq0, 32'd1);
        send_byte(8'hB4, 1'b0, ack);
        chk("R3 write address ack", {31'b0, ack}, 32'd1);
        irq0 = irq_cnt;
        send_byte(8'h3C, 1'b0, ack);
        chk("R7 data ack", {31'b0, ack}, 32'd1);
        chk("R2 irq on buffered byte", irq_cnt - irq0, 32'd1);
        host_read(2'd3, 1'b0, st);
        chk("R7 buffer full bit2", {31'b0, st[2]}, 32'd1);
        send_byte(8'hD1, 1'b0, ack);
        chk("R8 no ack on overflow", {31'b0, ack}, 32'd0);
        host_read(2'd3, 1'b0, st);
        chk("R8 overflow bit3", {31'b0, st[3]}, 32'd1);
        host_read(2'd0, 1'b1, d);
        chk("R8 old byte kept", {24'b0, d}, 32'h3C);
        host_read(2'd3, 1'b0, st);
        chk("R7 read clears bit2", {31'b0, st[2]}, 32'd0);
        host_write(2'd3, 8'h08);
        host_read(2'd3, 1'b0, st);
        chk("R8 overflow cleared", {31'b0, st[3]}, 32'd0);
        send_byte(8'h77, 1'b0, ack);
        chk("R7 refill ack", {31'b0, ack}, 32'd1);
        send_byte(8'h88, 1'b1, ack);
        chk("R9 same-cycle read ack", {31'b0, ack}, 32'd1);
        chk("R9 same-cycle read data", {24'b0, same_rd}, 32'h77);
        host_read(2'd3, 1'b0, st);
        chk("R9 no overflow", {31'b0, st[3]}, 32'd0);
        chk("R9 buffer full", {31'b0, st[2]}, 32'd1);
        host_read(2'd0, 1'b1, d);
        chk("R9 new byte buffered", {24'b0, d}, 32'h88);
        irq0 = irq_cnt;
        bus_stop();
        host_read(2'd3, 1'b0, st);
        chk("R1 stop sets bit1", {31'b0, st[1]}, 32'd1);
        chk("R1 stop clears bit0", {31'b0, st[0]}, 32'd0);
        chk("R2 irq on stop", irq_cnt - irq0, 32'd1);

        // R3: mismatch then later bytes ignored
        bus_start();
        send_byte(8'hB6, 1'b0, ack);
        chk("R3 mismatch no ack", {31'b0, ack}, 32'd0);
        send_byte(8'h3C, 1'b0, ack);
        chk("R3 later byte ignored", {31'b0, ack}, 32'd0);
        host_read(2'd3, 1'b0, st);
        chk("R3 buffer untouched", {31'b0, st[2]}, 32'd0);
        bus_stop();

        // R10, R11: 7-bit read of two bytes
        bus_start();
        send_byte(8'hB5, 1'b0, ack);
        chk("R10 read address ack", {31'b0, ack}, 32'd1);
        serve_read(8'hC3, 1'b1, "R10", d);
        chk("R10 first byte MSB first", {24'b0, d}, 32'hC3);
        serve_read(8'h5E, 1'b0, "R11", d);
        chk("R11 second byte after master ack", {24'b0, d}, 32'h5E);
        send_byte(8'hB4, 1'b0, ack);
        chk("R11 ignored after master nack", {31'b0, ack}, 32'd0);
        chk("R11 clock released", {31'b0, scl_oe}, 32'd0);
        bus_stop();
        host_read(2'd3, 1'b0, st);
        chk("R10 bit4 clear after transfer", {31'b0, st[4]}, 32'd0);

        // R5, R6: 10-bit addressing
        configure(1'b1, 1'b0, 10'h2A5);
        bus_start();
        send_byte(8'hF4, 1'b0, ack);
        chk("R5 10-bit first byte ack", {31'b0, ack}, 32'd1);
        send_byte(8'hA6, 1'b0, ack);
        chk("R5 low byte mismatch no ack", {31'b0, ack}, 32'd0);
        bus_stop();
        bus_start();
        send_byte(8'hF5, 1'b0, ack);
        chk("R6 read header without match", {31'b0, ack}, 32'd0);
        bus_stop();
        bus_start();
        send_byte(8'hF4, 1'b0, ack);
        send_byte(8'hA5, 1'b0, ack);
        chk("R5 low byte match ack", {31'b0, ack}, 32'd1);
        send_byte(8'h11, 1'b0, ack);
        chk("R5 data after 10-bit match ack", {31'b0, ack}, 32'd1);
        host_read(2'd0, 1'b1, d);
        chk("R5 data buffered", {24'b0, d}, 32'h11);
        bus_start();
        send_byte(8'hF5, 1'b0, ack);
        chk("R6 read header after repeated start", {31'b0, ack}, 32'd1);
        serve_read(8'h96, 1'b0, "R6", d);
        chk("R6 byte sent", {24'b0, d}, 32'h96);
        bus_stop();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule